// File: doc/BRIEF.md
# Indirect Channel Memory Access Engine

This block gives a host access to three per-channel internal memories (channel data, receive setup, transmit setup) through a four-register window, with no direct address map. The host puts a value in the data register and then writes a select word. The select word names a channel, a memory and a direction, and that one write launches a single access. A read copies the chosen entry into the data register. A write stores the data register into the chosen entry. A read-only busy flag in the select word shows when the access has finished.

The block also holds the port framing mode. In unchannelized operation every channel from 0 to 127 is valid. In channelized operation a two-bit rate code limits the channel range. An access that names the reserved memory code, or a channel beyond the current limit, touches no memory and sets a sticky error flag. The host clears that flag by reading it.

Host window (hostAddr): 0 is the select word, 1 is the data register, 2 is the mode register, 3 is the status register. Reads are combinational. A read strobe (hostRdEn) is needed only to clear the error flag.

Top module: `chan_ram_access`

## Requirements
- R1: After reset, all four window registers read 0. The mode then reads as channelized with rate code 00.
- R2: Select word layout:
  - bits 6:0 hold the channel.
  - bits 9:8 hold the memory code (00 data, 01 receive setup, 10 transmit setup, 11 reserved).
  - bit 14 is the direction (1 read, 0 write).
  - bit 15 is the read-only busy flag.
  - Every other bit reads 0.
- R3: A select write with direction 0 stores the data register into the chosen memory and channel. Busy reads 1 for exactly one cycle after the write.
- R4: A select write with direction 1 loads the chosen entry into the data register. Busy reads 1 for exactly two cycles, and the data is valid as soon as busy reads 0.
- R5: The three memories are independent. The same channel in each memory keeps its own value.
- R6: Mode register layout: bits 1:0 hold the rate code and bit 2 set means unchannelized. The last valid channel is:
  - 127 when unchannelized.
  - Otherwise 23, 31, 63 or 127 for rate codes 00, 01, 10 and 11.
- R7: A select write with memory code 11, or with a channel beyond the last valid one, modifies no memory. Busy reads 1 for one cycle, and status bit 0 (error) is then 1.
- R8: A status read with hostRdEn clears the error flag. If a new error is flagged on the same edge, the flag stays 1.
- R9: A select write while busy is 1 is ignored. The select word and the access in progress are unchanged.
- R10: A data register write while a read is busy is ignored. A data register write while a write access is busy is accepted, and the memory still receives the earlier data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe |
| hostRdEn | input | 1 | Host read strobe (clears error on status read) |
| hostAddr | input | 2 | Window register address |
| hostWrData | input | 16 | Host write data |
| hostRdData | output | 16 | Host read data for hostAddr |

## Verification
A sequencer stuck in a busy state shows at the ports as a busy bit that never drops, and the bench sees it one cycle after the expected release. A wrong legality decision shows in two ways: a stale or overwritten entry on a later read-back, or an error bit with the wrong value at the first status read after the access. Corrupt capture or a bad guard on the data register shows up in the data window as soon as busy falls. An access routed to the wrong memory shows up when the same channel is read back from each of the three memories.

// File: rtl/chan_ram_pkg.sv
package chan_ram_pkg;
  localparam int CHAN_W    = 7;
  localparam int DATA_W    = 16;
  localparam int NUM_MEMS  = 3;
  localparam int MSEL_W    = 2;
  localparam int DEPTH     = 1 << CHAN_W;

  localparam logic [CHAN_W-1:0] LAST_RATE0 = CHAN_W'(23);
  localparam logic [CHAN_W-1:0] LAST_RATE1 = CHAN_W'(31);
  localparam logic [CHAN_W-1:0] LAST_RATE2 = CHAN_W'(63);
  localparam logic [CHAN_W-1:0] LAST_FULL  = CHAN_W'(DEPTH - 1);

  localparam logic [1:0] ADDR_SEL    = 2'd0;
  localparam logic [1:0] ADDR_DATA   = 2'd1;
  localparam logic [1:0] ADDR_MODE   = 2'd2;
  localparam logic [1:0] ADDR_STATUS = 2'd3;

  localparam logic [MSEL_W-1:0] MSEL_BAD = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACCESS,
    ST_CAPTURE,
    ST_REJECT
  } accState_t;

  typedef struct packed {
    logic              memEn;
    logic              memWe;
    logic [MSEL_W-1:0] memSel;
    logic [CHAN_W-1:0] chan;
    logic              loadData;
  } ramStrobes_t;
endpackage

// File: rtl/chan_ram_ctrl.sv
module chan_ram_ctrl
  import chan_ram_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostWrEn,
  input  logic                hostRdEn,
  input  logic [1:0]          hostAddr,
  input  logic [DATA_W-1:0]   hostWrData,
  output ramStrobes_t         stb,
  output logic                readHold,
  output logic [DATA_W-1:0]   selWord,
  output logic [DATA_W-1:0]   modeWord,
  output logic [DATA_W-1:0]   statusWord
);
  accState_t         state;
  logic [CHAN_W-1:0] selChan;
  logic [MSEL_W-1:0] selMem;
  logic              selDir;
  logic [1:0]        rateCode;
  logic              unchan;
  logic              errFlag;
  logic              busy;
  logic              selWr;
  logic              modeWr;
  logic              errRd;
  logic [CHAN_W-1:0] chanLast;
  logic              reqLegal;
  logic [CHAN_W-1:0] wdChan;
  logic [MSEL_W-1:0] wdMem;
  logic              wdDir;
  logic              unusedWd;

  assign wdChan   = hostWrData[CHAN_W-1:0];
  assign wdMem    = hostWrData[9:8];
  assign wdDir    = hostWrData[14];
  assign unusedWd = ^{hostWrData[15], hostWrData[13:10], hostWrData[7]};

  assign busy   = (state != ST_IDLE);
  assign selWr  = hostWrEn && (hostAddr == ADDR_SEL) && !busy;
  assign modeWr = hostWrEn && (hostAddr == ADDR_MODE);
  assign errRd  = hostRdEn && (hostAddr == ADDR_STATUS);

  always_comb begin
    if (unchan) chanLast = LAST_FULL;
    else begin
      unique case (rateCode)
        2'b00:   chanLast = LAST_RATE0;
        2'b01:   chanLast = LAST_RATE1;
        2'b10:   chanLast = LAST_RATE2;
        default: chanLast = LAST_FULL;
      endcase
    end
  end

  assign reqLegal = (wdMem != MSEL_BAD) && (wdChan <= chanLast);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      selChan <= '0;
      selMem  <= '0;
      selDir  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (selWr) begin
          selChan <= wdChan;
          selMem  <= wdMem;
          selDir  <= wdDir;
          state   <= reqLegal ? ST_ACCESS : ST_REJECT;
        end
        ST_ACCESS:  state <= selDir ? ST_CAPTURE : ST_IDLE;
        ST_CAPTURE: state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rateCode <= 2'b00;
      unchan   <= 1'b0;
    end else if (modeWr) begin
      rateCode <= hostWrData[1:0];
      unchan   <= hostWrData[2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  errFlag <= 1'b0;
    else if (state == ST_REJECT) errFlag <= 1'b1;
    else if (errRd)             errFlag <= 1'b0;
  end

  always_comb begin
    stb.memEn    = (state == ST_ACCESS);
    stb.memWe    = (state == ST_ACCESS) && !selDir;
    stb.memSel   = selMem;
    stb.chan     = selChan;
    stb.loadData = (state == ST_CAPTURE);
  end

  assign readHold   = busy && selDir;
  assign selWord    = {busy, selDir, 4'b0000, selMem, 1'b0, selChan};
  assign modeWord   = {{(DATA_W-3){1'b0}}, unchan, rateCode};
  assign statusWord = {{(DATA_W-1){1'b0}}, errFlag};

  assert_sel_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && hostWrEn && hostAddr == ADDR_SEL) |=> $stable({selDir, selMem, selChan}));

  assert_reject_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REJECT) |=> (!busy && errFlag));

  assert_no_reserved_access_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.memEn |-> (stb.memSel != MSEL_BAD));

  assert_read_two_cycles_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.memEn && !stb.memWe) |=> (busy && stb.loadData));

  assert_write_one_cycle_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.memWe |=> !busy);
endmodule

// File: rtl/chan_ram_datapath.sv
module chan_ram_datapath
  import chan_ram_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ramStrobes_t        stb,
  input  logic               readHold,
  input  logic               dataWr,
  input  logic [DATA_W-1:0]  hostWrData,
  output logic [DATA_W-1:0]  dataReg
);
  logic [DATA_W-1:0] rdBus [NUM_MEMS];
  logic [DATA_W-1:0] rdMux;

  for (genvar g = 0; g < NUM_MEMS; g++) begin : gMem
    logic [DATA_W-1:0] store [DEPTH];
    logic [DATA_W-1:0] q;
    logic              hit;
    assign hit = stb.memEn && (stb.memSel == MSEL_W'(g));
    always_ff @(posedge clk) begin
      if (hit) begin
        if (stb.memWe) store[stb.chan] <= dataReg;
        q <= store[stb.chan];
      end
    end
    assign rdBus[g] = q;
  end

  always_comb begin
    rdMux = '0;
    for (int i = 0; i < NUM_MEMS; i++)
      if (stb.memSel == MSEL_W'(i)) rdMux = rdBus[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN)                    dataReg <= '0;
    else if (stb.loadData)        dataReg <= rdMux;
    else if (dataWr && !readHold) dataReg <= hostWrData;
  end

  assert_data_guard_R10: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && readHold && !stb.loadData) |=> $stable(dataReg));
endmodule

// File: rtl/chan_ram_access.sv
module chan_ram_access
  import chan_ram_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWrEn,
  input  logic               hostRdEn,
  input  logic [1:0]         hostAddr,
  input  logic [DATA_W-1:0]  hostWrData,
  output logic [DATA_W-1:0]  hostRdData
);
  ramStrobes_t       stb;
  logic              readHold;
  logic [DATA_W-1:0] selWord;
  logic [DATA_W-1:0] modeWord;
  logic [DATA_W-1:0] statusWord;
  logic [DATA_W-1:0] dataReg;
  logic              dataWr;

  assign dataWr = hostWrEn && (hostAddr == ADDR_DATA);

  chan_ram_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .hostWrEn   (hostWrEn),
    .hostRdEn   (hostRdEn),
    .hostAddr   (hostAddr),
    .hostWrData (hostWrData),
    .stb        (stb),
    .readHold   (readHold),
    .selWord    (selWord),
    .modeWord   (modeWord),
    .statusWord (statusWord)
  );

  chan_ram_datapath uData (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .readHold   (readHold),
    .dataWr     (dataWr),
    .hostWrData (hostWrData),
    .dataReg    (dataReg)
  );

  always_comb begin
    unique case (hostAddr)
      ADDR_SEL:  hostRdData = selWord;
      ADDR_DATA: hostRdData = dataReg;
      ADDR_MODE: hostRdData = modeWord;
      default:   hostRdData = statusWord;
    endcase
  end
endmodule

// File: tb/chan_ram_access_test.sv
`timescale 1ns/1ps
module chan_ram_access_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic        hostRdEn = 1'b0;
  logic [1:0]  hostAddr = 2'd0;
  logic [15:0] hostWrData = 16'h0;
  logic [15:0] hostRdData;

  int checks = 0;
  int errors = 0;
  logic [15:0] refMem [3][128];

  chan_ram_access uut (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData)
  );

  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] v);
    hostAddr = a;
    #1 v = hostRdData;
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [15:0] d);
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic readStatus(output logic [15:0] v);
    hostAddr = 2'd3; hostRdEn = 1'b1;
    #1 v = hostRdData;
    @(negedge clk);
    hostRdEn = 1'b0;
  endtask

  function automatic logic [15:0] selCode(input logic dir, input logic [1:0] m, input logic [6:0] ch);
    return {1'b0, dir, 4'b0000, m, 1'b0, ch};
  endfunction

  task automatic busyIs(input string tag, input logic exp);
    logic [15:0] v;
    peek(2'd0, v);
    check(tag, {15'h0, v[15]}, {15'h0, exp});
  endtask

  task automatic doWrite(input logic [1:0] m, input logic [6:0] ch, input logic [15:0] val);
    hostWrite(2'd1, val);
    hostWrite(2'd0, selCode(1'b0, m, ch));
    busyIs("R3 busy during write", 1'b1);
    @(negedge clk);
    busyIs("R3 busy released after write", 1'b0);
    refMem[m][ch] = val;
  endtask

  task automatic doRead(input string tag, input logic [1:0] m, input logic [6:0] ch);
    logic [15:0] v;
    hostWrite(2'd0, selCode(1'b1, m, ch));
    busyIs("R4 busy read cycle 1", 1'b1);
    @(negedge clk);
    busyIs("R4 busy read cycle 2", 1'b1);
    @(negedge clk);
    busyIs("R4 busy released after read", 1'b0);
    peek(2'd1, v);
    check(tag, v, refMem[m][ch]);
  endtask

  task automatic testReset();
    logic [15:0] v;
    for (int a = 0; a < 4; a++) begin
      peek(2'(a), v);
      check("R1 reset value", v, 16'h0);
    end
  endtask

  task automatic testLayout();
    logic [15:0] v;
    hostWrite(2'd2, 16'h0004);
    peek(2'd2, v);
    check("R6 mode readback", v, 16'h0004);
    hostWrite(2'd1, 16'h0A0A);
    hostWrite(2'd0, 16'hBDD5);
    peek(2'd0, v);
    check("R2 select layout while busy", v, 16'h8155);
    @(negedge clk);
    peek(2'd0, v);
    check("R2 select layout idle", v, 16'h0155);
    refMem[1][7'h55] = 16'h0A0A;
    doRead("R2 layout access reached memory 1", 2'd1, 7'h55);
  endtask

  task automatic testIndependent();
    doWrite(2'd0, 7'd5, 16'h1234);
    doWrite(2'd1, 7'd5, 16'h5678);
    doWrite(2'd2, 7'd5, 16'h9ABC);
    doRead("R5 data memory ch5", 2'd0, 7'd5);
    doRead("R5 receive memory ch5", 2'd1, 7'd5);
    doRead("R5 transmit memory ch5", 2'd2, 7'd5);
    doWrite(2'd2, 7'd127, 16'hFFEE);
    doRead("R3 write top channel", 2'd2, 7'd127);
  endtask

  task automatic testModes();
    logic [15:0] v;
    logic [6:0]  lastCh;
    logic [15:0] modeVal;
    logic [1:0]  m;
    for (int k = 0; k < 5; k++) begin
      case (k)
        0: begin lastCh = 7'd23;  modeVal = 16'h0000; end
        1: begin lastCh = 7'd31;  modeVal = 16'h0001; end
        2: begin lastCh = 7'd63;  modeVal = 16'h0002; end
        3: begin lastCh = 7'd127; modeVal = 16'h0003; end
        default: begin lastCh = 7'd127; modeVal = 16'h0004; end
      endcase
      m = 2'(k % 3);
      if (lastCh != 7'd127) begin
        hostWrite(2'd2, 16'h0004);
        doWrite(m, lastCh + 7'd1, 16'hA000 + 16'(k));
      end
      hostWrite(2'd2, modeVal);
      doWrite(m, lastCh, 16'hB000 + 16'(k));
      doRead("R6 last valid channel accepted", m, lastCh);
      readStatus(v);
      check("R6 legal access flags no error", v, 16'h0);
      if (lastCh != 7'd127) begin
        hostWrite(2'd1, 16'hC000 + 16'(k));
        hostWrite(2'd0, selCode(1'b0, m, lastCh + 7'd1));
        busyIs("R7 busy on out-of-range", 1'b1);
        @(negedge clk);
        busyIs("R7 busy released out-of-range", 1'b0);
        readStatus(v);
        check("R7 out-of-range sets error", v, 16'h0001);
        readStatus(v);
        check("R8 error cleared by read", v, 16'h0);
        hostWrite(2'd2, 16'h0004);
        doRead("R7 out-of-range left memory unchanged", m, lastCh + 7'd1);
      end
    end
  endtask

  task automatic testReserved();
    logic [15:0] v;
    hostWrite(2'd2, 16'h0004);
    doWrite(2'd0, 7'd3, 16'h0303);
    hostWrite(2'd1, 16'hEEEE);
    hostWrite(2'd0, selCode(1'b0, 2'b11, 7'd3));
    busyIs("R7 busy on reserved code", 1'b1);
    @(negedge clk);
    busyIs("R7 busy released reserved code", 1'b0);
    readStatus(v);
    check("R7 reserved code sets error", v, 16'h0001);
    doRead("R7 reserved code left memory 0 intact", 2'd0, 7'd3);
    hostWrite(2'd0, selCode(1'b0, 2'b11, 7'd4));
    readStatus(v);
    check("R8 status before same-edge set", v, 16'h0);
    peek(2'd3, v);
    check("R8 set wins over clear", v, 16'h0001);
    readStatus(v);
    check("R8 clear after set", v, 16'h0001);
    peek(2'd3, v);
    check("R8 cleared", v, 16'h0);
  endtask

  task automatic testBusyIgnore();
    logic [15:0] v;
    doWrite(2'd2, 7'd9, 16'h4444);
    doWrite(2'd1, 7'd10, 16'h5555);
    hostWrite(2'd0, selCode(1'b1, 2'd2, 7'd9));
    hostWrite(2'd0, selCode(1'b1, 2'd1, 7'd10));
    peek(2'd0, v);
    check("R9 select unchanged while busy", v, 16'hC209);
    @(negedge clk);
    busyIs("R9 original read finishes on time", 1'b0);
    peek(2'd1, v);
    check("R9 data from first access", v, 16'h4444);
    @(negedge clk);
    busyIs("R9 no second access started", 1'b0);
  endtask

  task automatic testDataGuard();
    logic [15:0] v;
    doWrite(2'd0, 7'd7, 16'h1111);
    hostWrite(2'd0, selCode(1'b1, 2'd0, 7'd7));
    hostWrite(2'd1, 16'hDEAD);
    hostWrite(2'd1, 16'hBEEF);
    busyIs("R10 read done", 1'b0);
    peek(2'd1, v);
    check("R10 data writes ignored during read", v, 16'h1111);
    hostWrite(2'd1, 16'h2222);
    hostWrite(2'd0, selCode(1'b0, 2'd0, 7'd7));
    hostWrite(2'd1, 16'h3333);
    peek(2'd1, v);
    check("R10 data write accepted during write access", v, 16'h3333);
    refMem[0][7] = 16'h2222;
    doRead("R10 memory took earlier data", 2'd0, 7'd7);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testLayout();
    testIndependent();
    testModes();
    testReserved();
    testBusyIgnore();
    testDataGuard();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule